// File: doc/BRIEF.md
# Configurable SPI Controller

A host-facing serial peripheral controller that runs either as bus master or as a selected slave. The host reaches four 16-bit registers through a 2-bit address: a configuration word, a status word, a select/count word and a data word. A write to the data word in master mode starts a full-duplex transfer. The serial clock is made by dividing the host clock. Polarity and phase are programmable, giving the four usual clock modes, and bits move most significant first.

The transfer length is 8 or 16 bits by default, or any length from 1 to 16 bits set in the select/count word. On completion the controller latches the received word, computes its parity, flags an overrun when the previous word was never read, and can raise an interrupt. In split-bus mode the host data word carries the byte to send in its low half and a new value for the eight select/control lines in its high half.

In slave mode the external serial clock and select are oversampled by the host clock. The serial output enable is asserted only while the slave is selected.

Top module: `spi_ctrl`

## Requirements
- R1: Register address decode: 0 = configuration, 1 = status, 2 = select/count, 3 = data. Configuration fields are [0] master, [1] polarity, [2] phase, [3] 16-bit width, [4] interrupt enable, [5] split-bus, [15:8] rate. Bits [7:6] read as zero. Select/count holds select lines in [15:8] and a bit count in [4:0], and bits [7:5] read as zero.
- R2: In master mode each serial clock half period lasts (rate+1)*DIV_UNIT host cycles. The serial clock rests at the polarity level when idle and after a transfer. The status done flag is set 2*N*(rate+1)*DIV_UNIT+2 cycles after the clock edge that accepts the data write.
- R3: Phase 0 samples input on the leading edge and changes output on the trailing edge. Phase 1 changes output on the leading edge (after the first bit) and samples on the trailing edge. Bits move most significant bit first, in all four polarity/phase combinations.
- R4: Length N is the count field when nonzero, with values above 16 clamped to 16. When the count field is zero, N is 16 if the width bit is set and split-bus is off, and 8 otherwise. The low N bits of the written word are sent. The N received bits are returned right-aligned and zero-extended.
- R5: Status bits: [0] done, [1] even parity (XOR) of the received word, [2] overrun, [3] busy.
- R6: Overrun is set when a transfer completes while the previous received word is still unread through the data register.
- R7: Reading status clears done and overrun.
- R8: irq_o equals done AND interrupt enable.
- R9: In split-bus mode a data write sends wdata_i[7:0] as an 8-bit word and loads wdata_i[15:8] onto sel_o.
- R10: A data write while a transfer is pending or running is ignored and starts no further transfer.
- R11: In slave mode a transfer runs while ss_ni is low, clocked by sclk_i, and returns the received word and done status. sdo_oe_o is low whenever ss_ni is high.
- R12: After reset, all registers read zero, sel_o is zero, sclk_o is low and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Host write data |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (side effects) |
| rdata_o | output | 16 | Register read data (combinational on addr_i) |
| irq_o | output | 1 | Completion interrupt |
| sclk_o | output | 1 | Serial clock out (master) |
| sclk_i | input | 1 | Serial clock in (slave) |
| ss_ni | input | 1 | Active-low slave select in |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial data output enable |
| sel_o | output | 8 | Slave select / control lines |

## Verification
The data write is registered once before the shift engine starts. The completion flag follows the last clock edge by one register, so the done flag and irq_o become visible exactly 2*N*H+2 host cycles after the accepting edge. The bench counts those cycles and compares the count with that figure. Serial data is observed on the negative host clock edge after each serial clock change, so every captured bit is read where the design holds it stable. Slave-mode stimulus holds each serial level for six or more host cycles, to cover the three-flop oversampling delay before checking sdo_o and status.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned CNT_W  = 5;
  localparam int unsigned ECNT_W = CNT_W + 1;
  localparam int unsigned SEL_W  = 8;
  localparam int unsigned RATE_W = 8;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_SCNT = 2'd2,
    REG_DATA = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic [1:0]        rsvd;
    logic              split;
    logic              irq_en;
    logic              wide;
    logic              cpha;
    logic              cpol;
    logic              master;
  } ctrl_t;

  function automatic logic [CNT_W-1:0] xfer_len(ctrl_t c, logic [CNT_W-1:0] cnt);
    if (cnt == '0)                  return (c.wide && !c.split) ? CNT_W'(16) : CNT_W'(8);
    else if (cnt > CNT_W'(WORD_W))  return CNT_W'(WORD_W);
    else                            return cnt;
  endfunction
endpackage

// File: rtl/spi_ctrl_div.sv
module spi_ctrl_div #(
  parameter int unsigned RATE_W = 8,
  parameter int unsigned UNIT   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam int unsigned CW = RATE_W + $clog2(UNIT) + 1;

  logic [CW-1:0] reload, cnt_q;

  assign reload = (CW'(rate_i) + CW'(1)) * CW'(UNIT) - CW'(1);
  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= reload;
    else if (cnt_q == '0)    cnt_q <= reload;
    else                     cnt_q <= cnt_q - CW'(1);
  end

  // R2: consecutive ticks only when the half period is a single cycle
  a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && $past(tick_o) && $past(run_i) && $stable(rate_i) |-> reload == '0);
endmodule

// File: rtl/spi_ctrl_engine.sv
module spi_ctrl_engine
  import spi_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              tick_i,
  input  logic              sclk_i,
  input  logic              ss_ni,
  input  logic              sdi_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              run_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic [2:0]        sclk_q, ss_q;
  logic              busy_q, done_q, sclk_r;
  logic [ECNT_W-1:0] ecnt_q;
  logic [CNT_W-1:0]  len_q;
  logic [WORD_W-1:0] tx_q, rx_q;

  logic s_edge, s_fall, s_sel, start, edge_evt, leading, do_sample, do_shift, last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      ss_q   <= '1;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk_i};
      ss_q   <= {ss_q[1:0], ss_ni};
    end
  end

  assign s_edge    = sclk_q[2] ^ sclk_q[1];
  assign s_fall    = ss_q[2] & ~ss_q[1];
  assign s_sel     = ~ss_q[1];
  assign start     = master_i ? (start_i & ~busy_q) : s_fall;
  assign edge_evt  = busy_q & (master_i ? tick_i : s_edge);
  assign leading   = ~ecnt_q[0];
  assign do_sample = edge_evt & (cpha_i ? ~leading : leading);
  assign do_shift  = edge_evt & (cpha_i ? (leading & (ecnt_q != '0)) : ~leading);
  assign last      = edge_evt & (ecnt_q == ({len_q, 1'b0} - ECNT_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_r <= 1'b0;
      ecnt_q <= '0;
      len_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        ecnt_q <= '0;
        len_q  <= len_i;
        tx_q   <= tx_word_i << (ECNT_W'(WORD_W) - ECNT_W'(len_i));
        rx_q   <= '0;
        sclk_r <= cpol_i;
      end else if (!master_i && busy_q && !s_sel) begin
        busy_q <= 1'b0;
      end else if (edge_evt) begin
        ecnt_q <= ecnt_q + ECNT_W'(1);
        sclk_r <= ~sclk_r;
        if (do_sample) rx_q <= {rx_q[WORD_W-2:0], sdi_i};
        if (do_shift)  tx_q <= tx_q << 1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign run_o     = busy_q & master_i;
  assign rx_word_o = rx_q;
  assign sclk_o    = (busy_q & master_i) ? sclk_r : cpol_i;
  assign sdo_o     = tx_q[WORD_W-1];
  assign sdo_oe_o  = master_i | ~ss_ni;

  // R2: an even number of toggles returns the clock to its rest level
  a_r2_sclk_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) && master_i |-> sclk_r == cpol_i);
  // R4: edge counter never passes 2*N-1
  a_r4_edge_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ecnt_q < {len_q, 1'b0});
  // R3: no serial activity while idle
  a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && !start |=> $stable(rx_q));
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
  import spi_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output ctrl_t             cfg_o,
  output logic [WORD_W-1:0] tx_word_o,
  output logic [CNT_W-1:0]  len_o,
  output logic              start_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              irq_o
);
  ctrl_t             cfg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] latch_q, hold_q;
  logic              start_q, done_f, par_f, ovr_f, unread_q;

  logic wr_ctrl, wr_scnt, wr_data, rd_stat, rd_data, busy_any;

  assign busy_any = busy_i | start_q;
  assign wr_ctrl  = we_i && (addr_i == REG_CTRL);
  assign wr_scnt  = we_i && (addr_i == REG_SCNT);
  assign wr_data  = we_i && (addr_i == REG_DATA) && !busy_any;
  assign rd_stat  = re_i && (addr_i == REG_STAT);
  assign rd_data  = re_i && (addr_i == REG_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      cnt_q    <= '0;
      sel_q    <= '0;
      latch_q  <= '0;
      hold_q   <= '0;
      start_q  <= 1'b0;
      done_f   <= 1'b0;
      par_f    <= 1'b0;
      ovr_f    <= 1'b0;
      unread_q <= 1'b0;
    end else begin
      start_q <= wr_data & cfg_q.master;
      if (wr_ctrl) begin
        cfg_q      <= ctrl_t'(wdata_i);
        cfg_q.rsvd <= '0;
      end
      if (wr_scnt) begin
        sel_q <= wdata_i[WORD_W-1 -: SEL_W];
        cnt_q <= wdata_i[CNT_W-1:0];
      end
      if (wr_data) begin
        if (cfg_q.split) begin
          latch_q <= {{(WORD_W-SEL_W){1'b0}}, wdata_i[SEL_W-1:0]};
          sel_q   <= wdata_i[WORD_W-1 -: SEL_W];
        end else begin
          latch_q <= wdata_i;
        end
      end
      if (rd_stat) begin
        done_f <= 1'b0;
        ovr_f  <= 1'b0;
      end
      if (rd_data) unread_q <= 1'b0;
      if (done_i) begin
        done_f   <= 1'b1;
        par_f    <= ^rx_word_i;
        hold_q   <= rx_word_i;
        unread_q <= 1'b1;
        if (unread_q && !rd_data) ovr_f <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      REG_CTRL: rdata_o = cfg_q;
      REG_STAT: rdata_o = {{(WORD_W-4){1'b0}}, busy_any, ovr_f, par_f, done_f};
      REG_SCNT: rdata_o = {sel_q, {(WORD_W-SEL_W-CNT_W){1'b0}}, cnt_q};
      default:  rdata_o = hold_q;
    endcase
  end

  assign cfg_o     = cfg_q;
  assign tx_word_o = latch_q;
  assign len_o     = xfer_len(cfg_q, cnt_q);
  assign start_o   = start_q;
  assign sel_o     = sel_q;
  assign irq_o     = done_f & cfg_q.irq_en;

  // R6: overrun only rises on a completion
  a_r6_ovr_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_f) |-> $past(done_i));
  // R5: completion always lands in the done flag
  a_r5_done_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> done_f);
  // R10: no start request while a transfer is in flight
  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !start_q);
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_ctrl_pkg::*;
#(
  parameter int unsigned DIV_UNIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sclk_o,
  input  logic              sclk_i,
  input  logic              ss_ni,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [SEL_W-1:0]  sel_o
);
  ctrl_t             cfg;
  logic [WORD_W-1:0] tx_word, rx_word;
  logic [CNT_W-1:0]  len;
  logic              start, busy, done, run, tick;

  spi_ctrl_regs u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .re_i, .rdata_o,
    .busy_i(busy), .done_i(done), .rx_word_i(rx_word),
    .cfg_o(cfg), .tx_word_o(tx_word), .len_o(len), .start_o(start),
    .sel_o, .irq_o
  );

  spi_ctrl_div #(.RATE_W(RATE_W), .UNIT(DIV_UNIT)) u_div (
    .clk_i, .rst_ni, .run_i(run), .rate_i(cfg.rate), .tick_o(tick)
  );

  spi_ctrl_engine u_engine (
    .clk_i, .rst_ni,
    .master_i(cfg.master), .cpol_i(cfg.cpol), .cpha_i(cfg.cpha),
    .start_i(start), .tx_word_i(tx_word), .len_i(len), .tick_i(tick),
    .sclk_i, .ss_ni, .sdi_i,
    .busy_o(busy), .done_o(done), .run_o(run), .rx_word_o(rx_word),
    .sclk_o, .sdo_o, .sdo_oe_o
  );
endmodule

// File: tb/spi_ctrl_bench.sv
`timescale 1ns/1ps
module spi_ctrl_bench;
  localparam int DIV_UNIT = 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        we = 1'b0, re = 1'b0, irq, sclk_o, sdo, sdo_oe;
  logic        t_sclk = 1'b0, t_ss_n = 1'b1, t_sdi = 1'b0, slave_mode = 1'b0;
  logic        m_sdi = 1'b0;
  logic [7:0]  sel;

  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  spi_ctrl #(.DIV_UNIT(DIV_UNIT)) u_spi_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .rdata_o(rdata), .irq_o(irq), .sclk_o(sclk_o), .sclk_i(t_sclk), .ss_ni(t_ss_n),
    .sdi_i(slave_mode ? t_sdi : m_sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sel_o(sel)
  );

  // bench-side serial peer for master transfers
  logic [15:0] m_pat = '0, m_cap = '0;
  int          m_n = 8, m_k = 0, m_gen = 0, m_seen = 0;
  bit          m_cpha = 1'b0, lead;
  logic        sprev = 1'b0;

  always @(negedge clk) begin
    if (m_gen != m_seen) begin
      m_seen = m_gen; m_k = 0; m_cap = '0; m_sdi = m_pat[m_n-1];
    end else if (sclk_o !== sprev) begin
      lead = (m_k % 2 == 0);
      if (m_cpha ? !lead : lead) m_cap = {m_cap[14:0], sdo};
      if (m_cpha && lead) m_sdi = m_pat[m_n-1-m_k/2];
      else if (!m_cpha && !lead && (m_n-2-(m_k-1)/2) >= 0) m_sdi = m_pat[m_n-2-(m_k-1)/2];
      m_k++;
    end
    sprev = sclk_o;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a; re = 1'b1;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    re = 1'b0;
  endtask

  function automatic logic [15:0] msk(input int n);
    return (n >= 16) ? 16'hFFFF : ((16'h1 << n) - 16'h1);
  endfunction

  // master transfer with peer; all results checked against arithmetic expectations
  task automatic xfer(input logic [15:0] txw, input logic [15:0] pat, input int n,
                      input int h, input bit cpol, input bit cpha);
    int cyc;
    logic [15:0] s, d;
    m_pat = pat; m_n = n; m_cpha = cpha; m_gen++;
    repeat (2) @(negedge clk);
    wr(2'd3, txw);
    cyc = 0;
    while (!irq && cyc < 2000) begin @(posedge clk); cyc++; @(negedge clk); end
    chk(cyc == 2*n*h*DIV_UNIT + 2, "R2 done latency", cyc, 2*n*h*DIV_UNIT + 2);
    chk(sclk_o == cpol, "R2 sclk rest level", sclk_o, cpol);
    chk(m_cap == (txw & msk(n)), "R3 R4 bits sent", m_cap, txw & msk(n));
    rd(2'd1, s);
    chk(s[0] == 1'b1 && s[1] == ^(pat & msk(n)), "R5 status done/parity", s, {^(pat & msk(n)), 1'b1});
    chk(irq == 1'b0, "R7 R8 irq cleared by status read", irq, 0);
    rd(2'd3, d);
    chk(d == (pat & msk(n)), "R3 R4 bits received", d, pat & msk(n));
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    logic [15:0] v, s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    rd(2'd0, v); chk(v == 16'h0, "R12 ctrl reset", v, 0);
    rd(2'd1, v); chk(v == 16'h0, "R12 status reset", v, 0);
    rd(2'd2, v); chk(v == 16'h0, "R12 scnt reset", v, 0);
    rd(2'd3, v); chk(v == 16'h0, "R12 data reset", v, 0);
    chk(sel == 8'h0 && sclk_o == 1'b0 && irq == 1'b0, "R12 outputs reset", {sel, sclk_o, irq}, 0);
    chk(sdo_oe == 1'b0, "R11 oe off when deselected", sdo_oe, 0);

    // R1: field layout readback
    wr(2'd0, 16'hFFFF); rd(2'd0, v); chk(v == 16'hFF3F, "R1 ctrl readback", v, 16'hFF3F);
    wr(2'd2, 16'hABFF); rd(2'd2, v); chk(v == 16'hAB1F, "R1 scnt readback", v, 16'hAB1F);
    chk(sel == 8'hAB, "R1 sel lines", sel, 8'hAB);
    wr(2'd0, 16'h0000); wr(2'd2, 16'h0000);

    // R2 R3 R4: sweep modes, lengths, rates
    for (int md = 0; md < 4; md++) begin
      for (int c = 0; c < 4; c++) begin
        for (int r = 0; r < 3; r += 2) begin
          bit w16; int cnt, n;
          logic [15:0] txw, pat;
          w16 = (c == 1 || c == 2);
          cnt = (c == 2) ? 5 : (c == 3) ? 20 : 0;
          n   = (c == 0) ? 8 : (c == 2) ? 5 : 16;
          txw = 16'hC3A5 ^ 16'((md*8 + c*2 + r) * 16'h1357);
          pat = 16'h5A0F + 16'((md*8 + c*2 + r) * 16'h0911);
          wr(2'd0, {8'(r), 2'b00, 1'b0, 1'b1, w16, md[1], md[0], 1'b1});
          wr(2'd2, {8'h00, 3'b000, 5'(cnt)});
          xfer(txw, pat, n, r + 1, md[0], md[1]);
        end
      end
    end

    // R9: split bus
    wr(2'd2, 16'h0000);
    wr(2'd0, {8'd1, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});
    xfer(16'hA53C, 16'h0096, 8, 2, 1'b0, 1'b0);
    chk(sel == 8'hA5, "R9 high byte to sel", sel, 8'hA5);
    rd(2'd2, v); chk(v[15:8] == 8'hA5, "R9 scnt shows sel", v, 16'hA500);

    // R6 R7: overrun
    wr(2'd0, {8'd0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1});
    xfer(16'h0011, 16'h0022, 8, 1, 1'b0, 1'b0);
    m_pat = 16'h0033; m_n = 8; m_cpha = 1'b0; m_gen++;
    repeat (2) @(negedge clk);
    wr(2'd3, 16'h0044); repeat (40) @(negedge clk);
    m_gen++; repeat (2) @(negedge clk);
    wr(2'd3, 16'h0055); repeat (40) @(negedge clk);
    rd(2'd1, s); chk((s & 16'h5) == 16'h5, "R6 overrun set", s & 16'h5, 5);
    rd(2'd1, s); chk((s & 16'h5) == 16'h0, "R7 status read clears", s & 16'h5, 0);
    rd(2'd3, v); chk(v == 16'h0033, "R6 newest word held", v, 16'h0033);

    // R10: write while busy
    wr(2'd0, {8'd3, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});
    m_pat = 16'h1234; m_n = 16; m_cpha = 1'b0; m_gen++;
    repeat (2) @(negedge clk);
    wr(2'd3, 16'hBEEF); repeat (10) @(negedge clk);
    wr(2'd3, 16'h0F0F);
    for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
    chk(m_cap == 16'hBEEF, "R10 first word kept", m_cap, 16'hBEEF);
    rd(2'd1, s); repeat (300) @(negedge clk);
    rd(2'd1, s); chk(s[3] == 1'b0 && s[0] == 1'b0, "R10 no second transfer", s, 0);
    rd(2'd3, v);

    // R11: slave mode, phase 0, 8 bits
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h00B6);
    slave_mode = 1'b1;
    chk(sdo_oe == 1'b0, "R11 oe off before select", sdo_oe, 0);
    t_ss_n = 1'b0; repeat (8) @(negedge clk);
    chk(sdo_oe == 1'b1, "R11 oe on when selected", sdo_oe, 1);
    begin
      logic [7:0] spat = 8'h6D, scap = '0;
      for (int i = 0; i < 8; i++) begin
        t_sdi = spat[7-i];
        repeat (6) @(negedge clk);
        scap = {scap[6:0], sdo};
        t_sclk = 1'b1; repeat (8) @(negedge clk);
        t_sclk = 1'b0; repeat (8) @(negedge clk);
      end
      chk(scap == 8'hB6, "R11 slave sent", scap, 8'hB6);
      rd(2'd1, s); chk(s[0] == 1'b1 && s[1] == ^spat, "R11 R5 slave status", s, {^spat, 1'b1});
      rd(2'd3, v); chk(v == {8'h00, spat}, "R11 slave received", v, spat);
    end
    t_ss_n = 1'b1; repeat (2) @(negedge clk);
    chk(sdo_oe == 1'b0, "R11 oe off after deselect", sdo_oe, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule